// File: doc/BRIEF.md
# Sequential Signed Multiplier with 32-bit Overflow Flag

This block multiplies two signed two's complement operands and returns only the low word of the product. Next to that word it raises a flag whenever the exact product lies outside the signed range of that word. A caller uses this to notice when a narrow-precision calculation has lost information and to switch to a fallback routine.

Operands are taken on a single-cycle `start` pulse while the block is idle. The general case runs a shift-add loop of one partial product per clock, W clocks in total, on the operand magnitudes. A final cycle then applies the sign and the range check. When either operand is 0, +1, -1, +2 or -2, a small decoder produces the answer directly and the loop is skipped. The ±1 and ±2 cases still report overflow, for example when the most negative value is negated.

The result and flag are registered. They stay unchanged until the next completion, which is marked by a one-cycle `done` pulse.

Top module: `smul_ovf`

## Requirements
- R1: In the general case `p` equals the low W bits of the exact product of `m` and `n`, both read as signed W-bit values.
- R2: `f` is 1 exactly when the exact product is below -2^(W-1) or above 2^(W-1)-1. Otherwise `f` is 0.
- R3: If either operand is zero, the block returns `p` = 0 and `f` = 0.
- R4: If either operand is +1 or -1, `p` is the other operand or its negation. `f` is set only for -1 times the most negative value.
- R5: If either operand is +2 or -2, `p` is the other operand doubled, and negated for -2. `f` is checked as in R2. Two examples: 2^(W-2) times -2 gives `f` = 0, and -2^(W-2) times -2 gives `f` = 1.
- R6: For the early-exit operands of R3 to R5, `done` rises on the first clock edge after `start` is sampled, and `busy` stays low.
- R7: In the general case, `busy` rises on the first edge after `start` and falls together with the rise of `done` on the (W+2)-th edge. `done` and `busy` are never high together.
- R8: A `start` pulse that arrives while `busy` is high is ignored. It produces no extra `done`, and it does not change the result of the operation in flight.
- R9: `done` is high for one cycle per accepted operation. `p` and `f` hold their values until the next completion.
- R10: After a synchronous reset, `busy`, `done`, `p` and `f` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept `m` and `n` when idle |
| m | input | W (32) | First signed operand |
| n | input | W (32) | Second signed operand |
| busy | output | 1 | Shift-add loop in progress |
| done | output | 1 | One-cycle completion pulse |
| p | output | W (32) | Low word of the product |
| f | output | 1 | Product not representable in W bits |

## Verification
The hardest cases to reach are the range edges of the doubled-and-negated path. There, a naive check on the top bits of the shifted operand gives the wrong answer, for example for 2^(W-2) times -2 and -2^(W-2) times -2. The bench drives these operand pairs explicitly, together with the most negative value against -1, against ±2 and against itself. It also injects a second `start` partway through a running loop, choosing operands that would finish early if accepted, so any leak shows up as a stray `done` or a changed result. Random operands with random magnitude masks cover products on both sides of the range limit.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic [2:0] {
    OPC_OTHER = 3'd0,
    OPC_ZERO  = 3'd1,
    OPC_POS1  = 3'd2,
    OPC_NEG1  = 3'd3,
    OPC_POS2  = 3'd4,
    OPC_NEG2  = 3'd5
  } opclass_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mstate_e;
endpackage

// File: rtl/smul_operand_class.sv
module smul_operand_class
  import smul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] val,
  output opclass_e     cls
);
  localparam logic [W-1:0] K_ONE  = W'(1);
  localparam logic [W-1:0] K_TWO  = W'(2);
  localparam logic [W-1:0] K_MONE = '1;
  localparam logic [W-1:0] K_MTWO = ~K_ONE;

  always_comb begin
    if (val == '0)          cls = OPC_ZERO;
    else if (val == K_ONE)  cls = OPC_POS1;
    else if (val == K_MONE) cls = OPC_NEG1;
    else if (val == K_TWO)  cls = OPC_POS2;
    else if (val == K_MTWO) cls = OPC_NEG2;
    else                    cls = OPC_OTHER;
  end
endmodule

// File: rtl/smul_early_path.sv
module smul_early_path
  import smul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] m,
  input  logic [W-1:0] n,
  input  opclass_e     cls_m,
  input  opclass_e     cls_n,
  output logic         hit,
  output logic [W-1:0] res,
  output logic         ovf
);
  localparam int XW = W + 2;

  logic         zero_case;
  logic         use_m_as_other;
  logic         dbl;
  logic         neg;
  logic [W-1:0] other;
  logic [XW-1:0] ext;
  logic [XW-1:0] scaled;
  logic [XW-1:0] signed_res;
  logic [2:0]    top_win;

  // pick the special operand: ±1 preferred over ±2, m preferred over n
  always_comb begin
    zero_case      = (cls_m == OPC_ZERO) || (cls_n == OPC_ZERO);
    hit            = 1'b1;
    use_m_as_other = 1'b0;
    dbl            = 1'b0;
    neg            = 1'b0;
    if (zero_case) begin
      hit = 1'b1;
    end else if (cls_m == OPC_POS1 || cls_m == OPC_NEG1) begin
      neg = (cls_m == OPC_NEG1);
    end else if (cls_n == OPC_POS1 || cls_n == OPC_NEG1) begin
      use_m_as_other = 1'b1;
      neg            = (cls_n == OPC_NEG1);
    end else if (cls_m == OPC_POS2 || cls_m == OPC_NEG2) begin
      dbl = 1'b1;
      neg = (cls_m == OPC_NEG2);
    end else if (cls_n == OPC_POS2 || cls_n == OPC_NEG2) begin
      use_m_as_other = 1'b1;
      dbl            = 1'b1;
      neg            = (cls_n == OPC_NEG2);
    end else begin
      hit = 1'b0;
    end
  end

  // exact arithmetic in W+2 bits, then test whether it fits in W bits
  always_comb begin
    other      = use_m_as_other ? m : n;
    ext        = {{2{other[W-1]}}, other};
    scaled     = dbl ? {ext[XW-2:0], 1'b0} : ext;
    signed_res = neg ? (~scaled + XW'(1)) : scaled;
    top_win    = signed_res[XW-1:W-1];
    if (zero_case) begin
      res = '0;
      ovf = 1'b0;
    end else begin
      res = signed_res[W-1:0];
      ovf = !((&top_win) || !(|top_win));
    end
  end
endmodule

// File: rtl/smul_shift_add.sv
module smul_shift_add #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   a_mag,
  input  logic [W-1:0]   b_mag,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  logic [PW-1:0] mcand;
  logic [W-1:0]  mplier;

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand  <= '0;
      mplier <= '0;
      prod   <= '0;
    end else if (load) begin
      mcand  <= {{W{1'b0}}, a_mag};
      mplier <= b_mag;
      prod   <= '0;
    end else if (step) begin
      if (mplier[0]) prod <= prod + mcand;
      mcand  <= {mcand[PW-2:0], 1'b0};
      mplier <= {1'b0, mplier[W-1:1]};
    end
  end
endmodule

// File: rtl/smul_ovf.sv
module smul_ovf
  import smul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] m,
  input  logic [W-1:0] n,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] p,
  output logic         f
);
  localparam int PW = 2 * W;
  localparam int CW = $clog2(W + 1);

  opclass_e       cls_m;
  opclass_e       cls_n;
  logic           early_hit;
  logic [W-1:0]   early_p;
  logic           early_f;
  logic [W-1:0]   mag_m;
  logic [W-1:0]   mag_n;
  logic           load;
  logic           step;
  logic [PW-1:0]  prod;
  logic [PW-1:0]  sprod;
  logic [W:0]     hi_win;
  logic           gen_ovf;
  mstate_e        state;
  logic [CW-1:0]  cnt;
  logic           neg_r;

  smul_operand_class #(.W(W)) u_cls_m (.val(m), .cls(cls_m));
  smul_operand_class #(.W(W)) u_cls_n (.val(n), .cls(cls_n));

  smul_early_path #(.W(W)) u_early (
    .m     (m),
    .n     (n),
    .cls_m (cls_m),
    .cls_n (cls_n),
    .hit   (early_hit),
    .res   (early_p),
    .ovf   (early_f)
  );

  // magnitudes: the most negative value maps to 2^(W-1) as unsigned
  always_comb begin
    mag_m = m[W-1] ? (~m + W'(1)) : m;
    mag_n = n[W-1] ? (~n + W'(1)) : n;
    load  = (state == ST_IDLE) && start && !early_hit;
    step  = (state == ST_RUN);
  end

  smul_shift_add #(.W(W)) u_core (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .step  (step),
    .a_mag (mag_m),
    .b_mag (mag_n),
    .prod  (prod)
  );

  always_comb begin
    sprod   = neg_r ? (~prod + PW'(1)) : prod;
    hi_win  = sprod[PW-1:W-1];
    gen_ovf = !((&hi_win) || !(|hi_win));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      neg_r <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
      p     <= '0;
      f     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (early_hit) begin
              p    <= early_p;
              f    <= early_f;
              done <= 1'b1;
            end else begin
              state <= ST_RUN;
              busy  <= 1'b1;
              cnt   <= CW'(W);
              neg_r <= m[W-1] ^ n[W-1];
            end
          end
        end
        ST_RUN: begin
          cnt <= cnt - CW'(1);
          if (cnt == CW'(1)) state <= ST_FIN;
        end
        ST_FIN: begin
          p     <= sprod[W-1:0];
          f     <= gen_ovf;
          done  <= 1'b1;
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smul_ovf_checker.sv
module smul_ovf_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [W-1:0] m,
  input logic [W-1:0] n,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] p,
  input logic         f,
  input logic         early_hit
);
  a_r6_early_done: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && early_hit) |=> (done && !busy));

  a_r7_general_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !early_hit) |=> (busy && !done));

  a_r7_done_excl_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r3_zero_result: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (m == '0 || n == '0)) |=> (p == '0 && !f));

  a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> (($stable(p) && $stable(f)) || done));

  a_r9_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
    (!start && !busy) |=> !done);

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));
endmodule

bind smul_ovf smul_ovf_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .m         (m),
  .n         (n),
  .busy      (busy),
  .done      (done),
  .p         (p),
  .f         (f),
  .early_hit (early_hit)
);

// File: tb/smul_ovf_bench.sv
module smul_ovf_bench;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] p;
    logic         f;
    int           lat;
    int           t0;
    string        req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] m = '0;
  logic [W-1:0] n = '0;
  logic         busy;
  logic         done;
  logic [W-1:0] p;
  logic         f;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   ended = 0;
  exp_t sb[$];
  logic [W-1:0] last_p = '0;
  logic         last_f = 1'b0;
  bit   have_last = 0;

  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] QTR  = {2'b01, {(W-2){1'b0}}};

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  smul_ovf #(.W(W)) u_smul_ovf (
    .clk(clk), .rst(rst), .start(start), .m(m), .n(n),
    .busy(busy), .done(done), .p(p), .f(f)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_special(input logic [W-1:0] v);
    return (v == '0) || (v == W'(1)) || (v == '1) || (v == W'(2)) || (v == ~W'(1));
  endfunction

  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    exp_t   e;
    longint pr;
    bit     early;
    while (busy) @(negedge clk);
    pr    = longint'($signed(a)) * longint'($signed(b));
    early = is_special(a) || is_special(b);
    e.p   = pr[W-1:0];
    e.f   = (pr != longint'($signed(pr[W-1:0])));
    e.lat = early ? 1 : W + 2;
    e.t0  = cyc;
    e.req = req;
    sb.push_back(e);
    m     = a;
    n     = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (early) check(busy == 1'b0, "R6", "busy on early path", busy, 0);
    else       check(busy == 1'b1, "R7", "busy in loop", busy, 1);
  endtask

  // monitor: pops expected items as results appear
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && done) begin
        if (sb.size() == 0) begin
          check(1'b0, "R8", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(p == e.p, e.req, "product", p, e.p);
          check(f == e.f, "R2", "overflow flag", f, e.f);
          check(cyc - e.t0 == e.lat, e.lat == 1 ? "R6" : "R7", "latency",
                cyc - e.t0, e.lat);
          last_p    = e.p;
          last_f    = e.f;
          have_last = 1;
        end
      end else if (!rst && have_last) begin
        check(p == last_p && f == last_f, "R9", "hold result", p, last_p);
      end
    end
  end

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R7", "watchdog expired", cyc, 0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check(busy == 1'b0, "R10", "busy after reset", busy, 0);
    check(done == 1'b0, "R10", "done after reset", done, 0);
    check(p == '0,      "R10", "p after reset", p, 0);
    check(f == 1'b0,    "R10", "f after reset", f, 0);

    // R3 zero operands
    issue('0, 32'h1234_5678, "R3");
    issue(MINV, '0, "R3");
    // R4 unit operands
    issue(W'(1), 32'hDEAD_BEEF, "R4");
    issue(32'h0000_7777, '1, "R4");
    issue('1, MINV, "R4");
    issue(MINV, W'(1), "R4");
    issue('1, '1, "R4");
    // R5 doubling operands, range edges
    issue(W'(2), QTR - W'(1), "R5");
    issue(QTR, W'(2), "R5");
    issue(QTR, ~W'(1), "R5");
    issue(~W'(1), ~QTR + W'(1), "R5");
    issue(~QTR + W'(1), ~W'(1), "R5");
    issue(~W'(1), MINV, "R5");
    issue(W'(2), MINV, "R5");
    // R1 general case corners
    issue(W'(3), W'(5), "R1");
    issue(32'hFFFF_FFFD, W'(7), "R1");
    issue(MINV, MINV, "R1");
    issue(MAXV, MAXV, "R1");
    issue(MINV, W'(3), "R1");
    issue(32'h0001_0000, 32'h0000_8000, "R1");
    issue(32'h0001_0000, 32'hFFFF_8000, "R1");
    issue(32'h0001_0000, 32'h0001_0000, "R1");

    // R8 start during busy is ignored (zero operand would finish early)
    issue(W'(12345), W'(-678), "R8");
    repeat (4) @(negedge clk);
    m = '0; n = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;

    // R1/R2 random operands across magnitudes
    for (int i = 0; i < 80; i++) begin
      logic [W-1:0] a, b;
      a = $urandom() >> ($urandom() % W);
      b = $urandom() >> ($urandom() % W);
      if ($urandom() % 2) a = ~a + W'(1);
      if ($urandom() % 2) b = ~b + W'(1);
      issue(a, b, "R1");
    end

    while (busy || sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R9", "scoreboard drained", sb.size(), 0);
    finish_up();
  end
endmodule